// File: doc/BRIEF.md
# Bit-Serial Associative Array Processor

The block is a small content-addressed store of N words of W bits. Each word has its own one-bit processing element. A serial controller drives a single command port. Through that port it loads words, a FLEN-bit key, a per-word enable vector and the two per-word tag vectors A and B. It also starts two array-wide operations.

The first operation is a key search. Every enabled word compares a FLEN-bit field, beginning at a bit column named in the command, against the key. The comparison runs one bit per cycle, and each word writes its own match result into A. The second operation takes one bit column of the store, ORs it with A word by word, and writes the result into B.

Words whose enable bit is clear take no part in either operation. A busy flag holds off new commands while a search is running, and a done pulse marks the end of each operation. A field that would run past the top bit of the word is refused with an error pulse. The controller reads back any word through a separate read address, and it sees A and B as N-bit vectors.

Top module: `aap_array`

## Requirements
- R1: After reset all words, tag vectors A and B and the key are zero, the enable vector is all ones, and busy, done and err are low.
- R2: A search at column c sets bit i of A to 1 when word i bits c+k equal key bits k for every k in 0..FLEN-1, and clears it to 0 otherwise.
- R3: A word whose enable bit is 0 keeps its A bit through a search and its B bit through an OR.
- R4: A search that is accepted holds busy high for exactly FLEN cycles after the accepting edge. A then takes its new value in the cycle busy falls, and done is high for that one cycle only.
- R5: A command presented while busy is high is ignored and changes no word, key, enable bit or tag.
- R6: An OR at column c sets B bit i to (word i bit c) OR (A bit i) for every enabled word. It leaves A unchanged, does not raise busy, and pulses done in the following cycle.
- R7: A search with c+FLEN greater than W is refused. err is high for one cycle after the accepting edge, busy stays low and neither tag vector changes. c = W-FLEN is accepted.
- R8: Loading a word writes cmd_wdata into word cmd_addr. rd_word shows word rd_addr without a clock delay, and tag_a and tag_b always show A and B.
- R9: cmd_op encodings: 0 none, 1 word load, 2 key load from cmd_wdata bits FLEN-1:0, 3 enable-vector load from cmd_vec, 4 search, 5 OR, 6 A load from cmd_vec, 7 B load from cmd_vec. A command is accepted on a rising edge where cmd_valid is high and busy is low.
- R10: An OR accepted in the cycle that a search's done is high uses the A vector that the search has just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_col | input | $clog2(W) | Start column for search or OR |
| cmd_addr | input | $clog2(N) | Word index for a word load |
| cmd_wdata | input | W | Word or key data |
| cmd_vec | input | N | Vector for enable, A or B loads |
| rd_addr | input | $clog2(N) | Word read index |
| rd_word | output | W | Word at rd_addr |
| tag_a | output | N | Tag vector A |
| tag_b | output | N | Tag vector B |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
Two functions can meet in the same cycle. The first is the last bit step of a search, which writes A. The second is the acceptance of an OR, which reads A. The bench provokes this by issuing an OR exactly in the cycle where done is high, and judges B against a behavioural model that applies the search result before the OR. A second overlap comes from commands held on the port while busy is high. Their effect is judged by reading back the targeted word and the tag vectors afterwards.

// File: rtl/aap_pkg.sv
package aap_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_WR_WORD = 3'd1,
        OP_LD_KEY  = 3'd2,
        OP_LD_EN   = 3'd3,
        OP_SEARCH  = 3'd4,
        OP_OR      = 3'd5,
        OP_LD_A    = 3'd6,
        OP_LD_B    = 3'd7
    } aap_op_e;

endpackage

// File: rtl/aap_seq.sv
module aap_seq
    import aap_pkg::*;
#(
    parameter int W    = 16,
    parameter int FLEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [$clog2(W)-1:0] cmd_col,
    input  logic [W-1:0]         cmd_wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic                 ld_word,
    output logic                 ld_en,
    output logic                 ld_a,
    output logic                 ld_b,
    output logic                 start,
    output logic                 step,
    output logic                 last,
    output logic                 or_en,
    output logic [$clog2(W)-1:0] col_sel,
    output logic                 key_bit
);

    localparam int CW   = $clog2(W);
    localparam int CNTW = $clog2(FLEN);

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        logic [CW-1:0]   col;
        logic [FLEN-1:0] key;
        logic            done;
        logic            err;
    } seq_s;

    seq_s cur_q, nxt_d;
    logic acc;
    aap_op_e op;
    logic [CW+1:0] end_pos;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.err  = 1'b0;
        ld_word  = 1'b0;
        ld_en    = 1'b0;
        ld_a     = 1'b0;
        ld_b     = 1'b0;
        start    = 1'b0;
        step     = 1'b0;
        last     = 1'b0;
        or_en    = 1'b0;
        acc      = cmd_valid && !cur_q.busy;
        op       = aap_op_e'(cmd_op);
        end_pos  = {2'b00, cmd_col} + (CW+2)'(FLEN);
        col_sel  = cur_q.busy ? (cur_q.col + CW'(cur_q.cnt)) : cmd_col;
        key_bit  = cur_q.key[cur_q.cnt];

        if (cur_q.busy) begin
            step = 1'b1;
            if (cur_q.cnt == CNTW'(FLEN - 1)) begin
                last       = 1'b1;
                nxt_d.busy = 1'b0;
                nxt_d.cnt  = '0;
                nxt_d.done = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end else if (acc) begin
            unique case (op)
                OP_WR_WORD: ld_word = 1'b1;
                OP_LD_KEY:  nxt_d.key = cmd_wdata[FLEN-1:0];
                OP_LD_EN:   ld_en = 1'b1;
                OP_LD_A:    ld_a = 1'b1;
                OP_LD_B:    ld_b = 1'b1;
                OP_SEARCH: begin
                    if (end_pos > (CW+2)'(W)) begin
                        nxt_d.err = 1'b1;
                    end else begin
                        nxt_d.busy = 1'b1;
                        nxt_d.cnt  = '0;
                        nxt_d.col  = cmd_col;
                        start      = 1'b1;
                    end
                end
                OP_OR: begin
                    if ({1'b0, cmd_col} >= (CW+1)'(W)) begin
                        nxt_d.err = 1'b1;
                    end else begin
                        or_en      = 1'b1;
                        nxt_d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy = cur_q.busy;
    assign done = cur_q.done;
    assign err  = cur_q.err;

endmodule

// File: rtl/aap_row.sv
module aap_row #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_word,
    input  logic [W-1:0]         wdata,
    input  logic                 ld_en,
    input  logic                 ld_a,
    input  logic                 ld_b,
    input  logic                 vec_bit,
    input  logic                 start,
    input  logic                 step,
    input  logic                 last,
    input  logic                 or_en,
    input  logic [$clog2(W)-1:0] col_sel,
    input  logic                 key_bit,
    output logic [W-1:0]         word_o,
    output logic                 en_o,
    output logic                 a_o,
    output logic                 b_o
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         en;
        logic         run;
        logic         a;
        logic         b;
    } row_s;

    row_s cur_q, nxt_d;
    logic sel;
    logic eq;

    always_comb begin
        nxt_d = cur_q;
        sel   = cur_q.word[col_sel];
        eq    = sel ~^ key_bit;
        if (ld_word) nxt_d.word = wdata;
        if (ld_en)   nxt_d.en   = vec_bit;
        if (ld_a)    nxt_d.a    = vec_bit;
        if (ld_b)    nxt_d.b    = vec_bit;
        if (start)   nxt_d.run  = 1'b1;
        if (step)    nxt_d.run  = cur_q.run & eq;
        if (last && cur_q.en)  nxt_d.a = cur_q.run & eq;
        if (or_en && cur_q.en) nxt_d.b = sel | cur_q.a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{word: '0, en: 1'b1, run: 1'b1, a: 1'b0, b: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign word_o = cur_q.word;
    assign en_o   = cur_q.en;
    assign a_o    = cur_q.a;
    assign b_o    = cur_q.b;

endmodule

// File: rtl/aap_array.sv
module aap_array #(
    parameter int N    = 8,
    parameter int W    = 16,
    parameter int FLEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [$clog2(W)-1:0] cmd_col,
    input  logic [$clog2(N)-1:0] cmd_addr,
    input  logic [W-1:0]         cmd_wdata,
    input  logic [N-1:0]         cmd_vec,
    input  logic [$clog2(N)-1:0] rd_addr,
    output logic [W-1:0]         rd_word,
    output logic [N-1:0]         tag_a,
    output logic [N-1:0]         tag_b,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);

    localparam int CW = $clog2(W);
    localparam int AW = $clog2(N);

    logic          ld_word, ld_en, ld_a, ld_b;
    logic          start, step, last, or_en, key_bit;
    logic [CW-1:0] col_sel;
    logic [W-1:0]  words [N];
    logic [N-1:0]  en_vec;

    aap_seq #(.W(W), .FLEN(FLEN)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_col  (cmd_col),
        .cmd_wdata(cmd_wdata),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .ld_word  (ld_word),
        .ld_en    (ld_en),
        .ld_a     (ld_a),
        .ld_b     (ld_b),
        .start    (start),
        .step     (step),
        .last     (last),
        .or_en    (or_en),
        .col_sel  (col_sel),
        .key_bit  (key_bit)
    );

    for (genvar g = 0; g < N; g++) begin : g_row
        aap_row #(.W(W)) row_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_word(ld_word && (cmd_addr == AW'(g))),
            .wdata  (cmd_wdata),
            .ld_en  (ld_en),
            .ld_a   (ld_a),
            .ld_b   (ld_b),
            .vec_bit(cmd_vec[g]),
            .start  (start),
            .step   (step),
            .last   (last),
            .or_en  (or_en),
            .col_sel(col_sel),
            .key_bit(key_bit),
            .word_o (words[g]),
            .en_o   (en_vec[g]),
            .a_o    (tag_a[g]),
            .b_o    (tag_b[g])
        );
    end

    assign rd_word = words[rd_addr];

endmodule

// File: rtl/aap_array_chk.sv
module aap_array_chk #(
    parameter int N    = 8,
    parameter int FLEN = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [N-1:0] tag_a,
    input logic [N-1:0] tag_b,
    input logic [N-1:0] en_vec
);

    localparam int RW = $clog2(FLEN) + 2;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(FLEN)));

    a_r4_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == RW'(FLEN - 1)));

    a_r4_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r7_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    a_r7_err_tags_held: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(tag_a) && $stable(tag_b)));

    a_r3_masked_a_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> (((tag_a ^ $past(tag_a)) & ~en_vec) == '0));

    a_r3_masked_b_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(busy)) |-> (((tag_b ^ $past(tag_b)) & ~en_vec) == '0));

    a_r6_or_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(busy)) |-> $stable(tag_a));

    a_r5_b_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(tag_b));

endmodule

bind aap_array aap_array_chk #(.N(N), .FLEN(FLEN)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .err   (err),
    .tag_a (tag_a),
    .tag_b (tag_b),
    .en_vec(en_vec)
);

// File: tb/aap_array_tb_top.sv
module aap_array_tb_top;

    localparam int N    = 8;
    localparam int W    = 16;
    localparam int FLEN = 4;
    localparam int CW   = $clog2(W);
    localparam int AW   = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [CW-1:0] cmd_col = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [W-1:0]  cmd_wdata = '0;
    logic [N-1:0]  cmd_vec = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_word;
    logic [N-1:0]  tag_a, tag_b;
    logic          busy, done, err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    aap_array #(.N(N), .W(W), .FLEN(FLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_col(cmd_col), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_vec(cmd_vec), .rd_addr(rd_addr), .rd_word(rd_word),
        .tag_a(tag_a), .tag_b(tag_b), .busy(busy), .done(done), .err(err)
    );

    // behavioural reference
    logic [W-1:0]    m_word [N];
    logic [N-1:0]    m_en, m_a, m_b;
    logic [FLEN-1:0] m_key;
    bit              m_busy, m_done, m_err;
    int              m_cnt, m_col;

    function automatic bit field_hit(logic [W-1:0] w, int col, logic [FLEN-1:0] key);
        for (int k = 0; k < FLEN; k++) if (w[col+k] !== key[k]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_word[i] = '0;
            m_en = '1; m_a = '0; m_b = '0; m_key = '0;
            m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_col = 0;
        end else begin
            m_done = 0;
            m_err  = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == FLEN) begin
                    m_busy = 0;
                    m_done = 1;
                    for (int i = 0; i < N; i++)
                        if (m_en[i]) m_a[i] = field_hit(m_word[i], m_col, m_key);
                end
            end else if (cmd_valid) begin
                case (cmd_op)
                    3'd1: m_word[cmd_addr] = cmd_wdata;
                    3'd2: m_key = cmd_wdata[FLEN-1:0];
                    3'd3: m_en = cmd_vec;
                    3'd4: begin
                        if (int'(cmd_col) + FLEN > W) m_err = 1;
                        else begin m_busy = 1; m_cnt = 0; m_col = int'(cmd_col); end
                    end
                    3'd5: begin
                        for (int i = 0; i < N; i++)
                            if (m_en[i]) m_b[i] = m_word[i][cmd_col] | m_a[i];
                        m_done = 1;
                    end
                    3'd6: m_a = cmd_vec;
                    3'd7: m_b = cmd_vec;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cycles++;
            chk("R4 R5 busy", 64'(busy), 64'(m_busy));
            chk("R4 R6 done", 64'(done), 64'(m_done));
            chk("R7 err", 64'(err), 64'(m_err));
            chk("R2 R3 tag_a", 64'(tag_a), 64'(m_a));
            chk("R6 R3 tag_b", 64'(tag_b), 64'(m_b));
            chk("R8 R5 rd_word", 64'(rd_word), 64'(m_word[rd_addr]));
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic cmd(logic [2:0] op, int col, int addr, logic [W-1:0] d, logic [N-1:0] v);
        cmd_valid = 1'b1; cmd_op = op; cmd_col = CW'(col);
        cmd_addr = AW'(addr); cmd_wdata = d; cmd_vec = v;
        tick(1);
        cmd_valid = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 tag_a", 64'(tag_a), 0);
        chk("R1 tag_b", 64'(tag_b), 0);
        chk("R1 busy", 64'(busy), 0);
        chk("R1 rd_word", 64'(rd_word), 0);

        // R9 R8 loads: word 0 = 0x00A0, key = 0xA
        cmd(3'd1, 0, 0, 16'h00A0, '0);
        cmd(3'd2, 0, 0, 16'h000A, '0);
        cmd(3'd4, 4, 0, '0, '0);
        chk("R4 busy after accept", 64'(busy), 1);
        tick(FLEN);
        chk("R4 done pulse", 64'(done), 1);
        chk("R2 search hit word0", 64'(tag_a), 64'h01);
        tick(1);
        chk("R4 done one cycle", 64'(done), 0);

        // R7 boundary and refusal
        cmd(3'd4, W - FLEN + 1, 0, '0, '0);
        chk("R7 err pulse", 64'(err), 1);
        chk("R7 no busy", 64'(busy), 0);
        tick(1);
        cmd(3'd4, W - FLEN, 0, '0, '0);
        chk("R7 last legal column accepted", 64'(busy), 1);
        // R5 word load while busy is dropped
        cmd(3'd1, 0, 0, 16'hFFFF, '0);
        tick(FLEN);
        rd_addr = '0; #1;
        chk("R5 word unchanged", 64'(rd_word), 64'h00A0);

        // R3 masked search: preset A, disable odd words
        cmd(3'd6, 0, 0, '0, 8'hF0);
        cmd(3'd3, 0, 0, '0, 8'h55);
        cmd(3'd4, 0, 0, '0, '0);
        tick(FLEN);
        // R10 OR accepted in the done cycle
        cmd(3'd5, 5, 0, '0, '0);
        chk("R10 back-to-back OR", 64'(tag_b), 64'(m_b));
        cmd(3'd3, 0, 0, '0, '1);

        // mixed traffic
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom_range(0, 9));
            logic [2:0] op = (r > 7) ? 3'd4 : 3'(r);
            cmd(op, int'($urandom_range(0, W - 1)), int'($urandom_range(0, N - 1)),
                W'($urandom), N'($urandom));
            rd_addr = AW'($urandom_range(0, N - 1));
            tick(int'($urandom_range(0, 2)));
        end
        tick(FLEN + 2);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule